// File: doc/BRIEF.md
# NAND Flash Asynchronous Access Sequencer

This block runs one read or one write data cycle on a raw NAND flash device. It runs on the controller clock and counts every interval in whole clock cycles. A request carries a direction flag and, for writes, a data word. The block turns it into chip-enable, read-strobe and write-strobe waveforms inside an access window of fixed length. It drives or samples the data lines and reports completion with a single-cycle done pulse. No address lines are driven. Command and address latch sequencing belongs to a neighbouring block.

The device's ready/busy line is sampled as a busy input. A request that arrives while the device is busy, or while a window is already running, is held in a one-deep pending slot. It starts as soon as the block is idle and the device is ready. Chip enable is released inside every window, so the device can finish an internal program, erase or page load while deselected.

The strobe release points, the chip-enable release point and the read sample point can be loaded at run time, along with the data width (16 bits or 8 bits). A load is taken only between windows, and only if the whole set of values is legal.

Top module: `nand_cycle_seq`

## Requirements
- R1: After reset all three strobes are high, no data lane is driven, the done flag and read data are zero, the data width is 16 bits and the timing set is: read-strobe release 20, write-strobe release 20, chip-enable release 28, sample point 19.
- R2: A window lasts 30 clocks, numbered 0 to 29 from the clock in which chip enable first reads low. The done flag is high during clock 29 only, and at least one idle clock separates two windows.
- R3: Chip enable is low from clock 0 up to and excluding the programmed chip-enable release clock, and high at every other time.
- R4: On a read, the read strobe is low from clock 7 up to and excluding its programmed release clock. The write strobe stays high.
- R5: On a write, the write strobe is low from clock 5 up to and excluding its programmed release clock. The write word is driven, with the lane-enable bits set, during exactly those clocks. The read strobe stays high. At every other time the data output is zero with all lane enables clear.
- R6: On a read, the data lines are sampled at the clock edge that ends window clock equal to the sample point. The result is on the read-data output from the next clock until the next read. A write leaves the read data unchanged.
- R7: With the width set to 8 bits, only lane 0 (bits 7:0, lane-enable bit 0) is driven. The upper byte of the read data is captured as zero.
- R8: A request sampled while the block is idle with busy low starts a window two clocks later. While busy is high no window starts. A window starts in the clock after busy is seen low with a request pending.
- R9: A request arriving during a window is held and runs in a window that begins two clocks after the done clock. A further request that arrives while one is pending is ignored.
- R10: A timing load takes effect only if it arrives while idle and every value is legal. Legal means: all offsets below 30, sample point below 29, read-strobe release above 7, write-strobe release above 5, both strobe releases not later than the chip-enable release, and chip-enable release above 0. Any other load is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request, sampled each clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write word |
| cfg_load | input | 1 | Load the timing and width set |
| cfg_bus8 | input | 1 | 1 = 8-bit data width |
| cfg_oe_off | input | 8 | Read-strobe release clock |
| cfg_we_off | input | 8 | Write-strobe release clock |
| cfg_ce_off | input | 8 | Chip-enable release clock |
| cfg_cap | input | 8 | Read sample clock |
| nand_busy | input | 1 | Device busy (high = busy) |
| nand_dq_i | input | 16 | Data lines from device |
| nand_dq_o | output | 16 | Data lines to device |
| nand_dq_oe | output | 2 | Per-byte-lane output enable |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_oe_n | output | 1 | Read strobe, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| rd_data | output | 16 | Last captured read word |
| acc_done | output | 1 | Window-complete pulse |

## Verification
The hardest situation to reach is a second and a third request, plus a timing load, all landing in the middle of a running window. The queued access must then start on the exact clock after the idle gap, carry the second request's data, and use the old timing. The bench gets there by firing those pulses from inside the window-checking task at fixed clock numbers. The sample point is checked by putting the wanted word on the data lines only during the sample clock and its complement at all other clocks.

// File: rtl/nseq_pkg.sv
package nseq_pkg;
  parameter int OFS_W = 8;

  typedef enum logic {OP_READ = 1'b0, OP_WRITE = 1'b1} op_e;

  typedef struct packed {
    logic [OFS_W-1:0] oe_off;
    logic [OFS_W-1:0] we_off;
    logic [OFS_W-1:0] ce_off;
    logic [OFS_W-1:0] cap;
    logic             bus8;
  } tcfg_t;
endpackage

// File: rtl/nseq_cfg.sv
module nseq_cfg import nseq_pkg::*; #(
  parameter int CYC_LEN    = 30,
  parameter int OE_ON      = 7,
  parameter int WE_ON      = 5,
  parameter int OE_OFF_DEF = 20,
  parameter int WE_OFF_DEF = 20,
  parameter int CE_OFF_DEF = 28,
  parameter int CAP_DEF    = 19
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  idle,
  input  logic  ld,
  input  tcfg_t ld_val,
  output tcfg_t cfg
);
  localparam logic [OFS_W-1:0] LEN_V = OFS_W'(CYC_LEN);

  logic legal;
  always_comb begin
    legal = (ld_val.oe_off < LEN_V) && (ld_val.we_off < LEN_V) &&
            (ld_val.ce_off < LEN_V) && (ld_val.cap < LEN_V - 1'b1) &&
            (ld_val.oe_off > OFS_W'(OE_ON)) && (ld_val.we_off > OFS_W'(WE_ON)) &&
            (ld_val.oe_off <= ld_val.ce_off) && (ld_val.we_off <= ld_val.ce_off) &&
            (ld_val.ce_off != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.oe_off <= OFS_W'(OE_OFF_DEF);
      cfg.we_off <= OFS_W'(WE_OFF_DEF);
      cfg.ce_off <= OFS_W'(CE_OFF_DEF);
      cfg.cap    <= OFS_W'(CAP_DEF);
      cfg.bus8   <= 1'b0;
    end else if (ld && idle && legal) begin
      cfg <= ld_val;
    end
  end

  assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    !idle |=> $stable(cfg));
  assert_cfg_in_window_R10: assert property (@(posedge clk) disable iff (rst)
    (cfg.ce_off < LEN_V) && (cfg.oe_off <= cfg.ce_off) && (cfg.we_off <= cfg.ce_off));
endmodule

// File: rtl/nseq_ctrl.sv
module nseq_ctrl import nseq_pkg::*; #(
  parameter int DW      = 16,
  parameter int CYC_LEN = 30,
  parameter int CW      = $clog2(CYC_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  input  logic          busy,
  output logic          idle,
  output logic          active,
  output logic [CW-1:0] cnt,
  output op_e           op,
  output logic          nxt_active,
  output logic [CW-1:0] nxt_cnt,
  output op_e           nxt_op,
  output logic [DW-1:0] nxt_wd
);
  localparam logic [CW-1:0] LAST = CW'(CYC_LEN - 1);

  logic          pend;
  op_e           pend_op;
  logic [DW-1:0] pend_wd;
  logic [DW-1:0] wd;
  logic          start;

  assign idle  = !active;
  assign start = !active && pend && !busy;

  always_comb begin
    nxt_active = start || (active && cnt != LAST);
    nxt_cnt    = (start || !active || cnt == LAST) ? '0 : cnt + 1'b1;
    nxt_op     = start ? pend_op : op;
    nxt_wd     = start ? pend_wd : wd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= 1'b0;
      pend_op <= OP_READ;
      pend_wd <= '0;
      active  <= 1'b0;
      cnt     <= '0;
      op      <= OP_READ;
      wd      <= '0;
    end else begin
      if (start) begin
        pend <= 1'b0;
      end else if (req_valid && !pend) begin
        pend    <= 1'b1;
        pend_op <= req_write ? OP_WRITE : OP_READ;
        pend_wd <= req_wdata;
      end
      active <= nxt_active;
      cnt    <= nxt_cnt;
      op     <= nxt_op;
      wd     <= nxt_wd;
    end
  end

  assert_start_when_ready_R8: assert property (@(posedge clk) disable iff (rst)
    (active && cnt == '0) |-> $past(!busy));
  assert_idle_gap_R2: assert property (@(posedge clk) disable iff (rst)
    (active && cnt == LAST) |=> !active);
  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt <= LAST));
endmodule

// File: rtl/nseq_phy.sv
module nseq_phy import nseq_pkg::*; #(
  parameter int DW      = 16,
  parameter int CYC_LEN = 30,
  parameter int OE_ON   = 7,
  parameter int WE_ON   = 5,
  parameter int CW      = $clog2(CYC_LEN),
  parameter int NL      = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  tcfg_t         cfg,
  input  logic          active,
  input  logic [CW-1:0] cnt,
  input  op_e           op,
  input  logic          nxt_active,
  input  logic [CW-1:0] nxt_cnt,
  input  op_e           nxt_op,
  input  logic [DW-1:0] nxt_wd,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] dq_o,
  output logic [NL-1:0] dq_oe,
  output logic          ce_n,
  output logic          oe_n,
  output logic          we_n,
  output logic [DW-1:0] rd_data,
  output logic          done
);
  logic [OFS_W-1:0] k_nxt;
  logic [OFS_W-1:0] k_cur;
  logic             ce_on, oe_on, we_on, cap_now;

  assign k_nxt   = OFS_W'(nxt_cnt);
  assign k_cur   = OFS_W'(cnt);
  assign ce_on   = nxt_active && (k_nxt < cfg.ce_off);
  assign oe_on   = nxt_active && (nxt_op == OP_READ) &&
                   (k_nxt >= OFS_W'(OE_ON)) && (k_nxt < cfg.oe_off);
  assign we_on   = nxt_active && (nxt_op == OP_WRITE) &&
                   (k_nxt >= OFS_W'(WE_ON)) && (k_nxt < cfg.we_off);
  assign cap_now = active && (op == OP_READ) && (k_cur == cfg.cap);

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_n <= 1'b1;
      oe_n <= 1'b1;
      we_n <= 1'b1;
      done <= 1'b0;
    end else begin
      ce_n <= !ce_on;
      oe_n <= !oe_on;
      we_n <= !we_on;
      done <= nxt_active && (k_nxt == OFS_W'(CYC_LEN - 1));
    end
  end

  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic       lane_on;
    logic [7:0] out_q;
    logic [7:0] rd_q;
    logic       oe_q;

    assign lane_on = (l == 0) || !cfg.bus8;

    always_ff @(posedge clk) begin
      if (rst) begin
        out_q <= '0;
        oe_q  <= 1'b0;
        rd_q  <= '0;
      end else begin
        oe_q  <= we_on && lane_on;
        out_q <= (we_on && lane_on) ? nxt_wd[l*8 +: 8] : 8'h00;
        if (cap_now) rd_q <= lane_on ? dq_i[l*8 +: 8] : 8'h00;
      end
    end

    assign dq_o[l*8 +: 8]    = out_q;
    assign rd_data[l*8 +: 8] = rd_q;
    assign dq_oe[l]          = oe_q;
  end

  if (NL > 1) begin : g_narrow_chk
    assert_upper_lanes_quiet_R7: assert property (@(posedge clk) disable iff (rst)
      cfg.bus8 |-> (dq_oe[NL-1:1] == '0));
  end

  assert_oe_inside_ce_R4: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> !ce_n);
  assert_we_inside_ce_R5: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> !ce_n);
  assert_no_dual_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    !(!oe_n && !we_n));
  assert_no_bus_fight_R5: assert property (@(posedge clk) disable iff (rst)
    (|dq_oe) |-> oe_n);
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq import nseq_pkg::*; #(
  parameter int DW         = 16,
  parameter int CYC_LEN    = 30,
  parameter int OE_ON      = 7,
  parameter int WE_ON      = 5,
  parameter int OE_OFF_DEF = 20,
  parameter int WE_OFF_DEF = 20,
  parameter int CE_OFF_DEF = 28,
  parameter int CAP_DEF    = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [DW-1:0]    req_wdata,
  input  logic             cfg_load,
  input  logic             cfg_bus8,
  input  logic [OFS_W-1:0] cfg_oe_off,
  input  logic [OFS_W-1:0] cfg_we_off,
  input  logic [OFS_W-1:0] cfg_ce_off,
  input  logic [OFS_W-1:0] cfg_cap,
  input  logic             nand_busy,
  input  logic [DW-1:0]    nand_dq_i,
  output logic [DW-1:0]    nand_dq_o,
  output logic [DW/8-1:0]  nand_dq_oe,
  output logic             nand_ce_n,
  output logic             nand_oe_n,
  output logic             nand_we_n,
  output logic [DW-1:0]    rd_data,
  output logic             acc_done
);
  localparam int CW = $clog2(CYC_LEN);
  localparam int NL = DW / 8;

  tcfg_t         cfg, ld_val;
  logic          idle, active, nxt_active;
  logic [CW-1:0] cnt, nxt_cnt;
  op_e           op, nxt_op;
  logic [DW-1:0] nxt_wd;

  assign ld_val = '{oe_off: cfg_oe_off, we_off: cfg_we_off,
                    ce_off: cfg_ce_off, cap: cfg_cap, bus8: cfg_bus8};

  nseq_cfg #(.CYC_LEN(CYC_LEN), .OE_ON(OE_ON), .WE_ON(WE_ON),
             .OE_OFF_DEF(OE_OFF_DEF), .WE_OFF_DEF(WE_OFF_DEF),
             .CE_OFF_DEF(CE_OFF_DEF), .CAP_DEF(CAP_DEF)) u_cfg (
    .clk(clk), .rst(rst), .idle(idle), .ld(cfg_load), .ld_val(ld_val), .cfg(cfg)
  );

  nseq_ctrl #(.DW(DW), .CYC_LEN(CYC_LEN), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_wdata(req_wdata), .busy(nand_busy), .idle(idle), .active(active),
    .cnt(cnt), .op(op), .nxt_active(nxt_active), .nxt_cnt(nxt_cnt),
    .nxt_op(nxt_op), .nxt_wd(nxt_wd)
  );

  nseq_phy #(.DW(DW), .CYC_LEN(CYC_LEN), .OE_ON(OE_ON), .WE_ON(WE_ON),
             .CW(CW), .NL(NL)) u_phy (
    .clk(clk), .rst(rst), .cfg(cfg), .active(active), .cnt(cnt), .op(op),
    .nxt_active(nxt_active), .nxt_cnt(nxt_cnt), .nxt_op(nxt_op),
    .nxt_wd(nxt_wd), .dq_i(nand_dq_i), .dq_o(nand_dq_o), .dq_oe(nand_dq_oe),
    .ce_n(nand_ce_n), .oe_n(nand_oe_n), .we_n(nand_we_n),
    .rd_data(rd_data), .done(acc_done)
  );
endmodule

// File: tb/nand_cycle_seq_tb.sv
module nand_cycle_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LEN = 30;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        cfg_load = 1'b0, cfg_bus8 = 1'b0;
  logic [7:0]  cfg_oe_off = '0, cfg_we_off = '0, cfg_ce_off = '0, cfg_cap = '0;
  logic        nand_busy = 1'b0;
  logic [15:0] nand_dq_i = '0;
  logic [15:0] nand_dq_o, rd_data;
  logic [1:0]  nand_dq_oe;
  logic        nand_ce_n, nand_oe_n, nand_we_n, acc_done;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  int m_oe = 20, m_we = 20, m_ce = 28, m_cap = 19;
  bit m_b8 = 0;
  logic [15:0] m_rd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_cycle_seq u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_wdata(req_wdata), .cfg_load(cfg_load), .cfg_bus8(cfg_bus8),
    .cfg_oe_off(cfg_oe_off), .cfg_we_off(cfg_we_off), .cfg_ce_off(cfg_ce_off),
    .cfg_cap(cfg_cap), .nand_busy(nand_busy), .nand_dq_i(nand_dq_i),
    .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe), .nand_ce_n(nand_ce_n),
    .nand_oe_n(nand_oe_n), .nand_we_n(nand_we_n), .rd_data(rd_data),
    .acc_done(acc_done)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", rq, what, act, exp, $time);
    end
  endtask

  task automatic pulse_req(input bit wr, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic load_cfg(input int oe, input int we, input int ce, input int cap, input bit b8);
    bit legal;
    legal = oe < LEN && we < LEN && ce < LEN && cap < LEN - 1 && oe > 7 && we > 5 &&
            oe <= ce && we <= ce && ce > 0;
    @(negedge clk);
    cfg_load = 1'b1; cfg_oe_off = 8'(oe); cfg_we_off = 8'(we);
    cfg_ce_off = 8'(ce); cfg_cap = 8'(cap); cfg_bus8 = b8;
    @(negedge clk);
    cfg_load = 1'b0;
    if (legal) begin
      m_oe = oe; m_we = we; m_ce = ce; m_cap = cap; m_b8 = b8;
    end
  endtask

  // Called at the negedge just before window clock 0; checks every clock of the window.
  task automatic run_window(input bit wr, input logic [15:0] wd, input logic [15:0] rv,
                            input bit inj);
    for (int k = 0; k < LEN; k++) begin
      bit drv;
      logic [1:0]  exp_oe;
      logic [15:0] exp_o;
      @(negedge clk);
      nand_dq_i = (k == m_cap) ? rv : ~rv;
      if (inj) begin
        if (k == 10) begin req_valid = 1'b1; req_write = 1'b1; req_wdata = 16'hBEEF; end
        if (k == 11) req_valid = 1'b0;
        if (k == 12) begin req_valid = 1'b1; req_write = 1'b0; req_wdata = 16'h0BAD; end
        if (k == 13) req_valid = 1'b0;
        if (k == 14) begin
          cfg_load = 1'b1; cfg_oe_off = 8'd9; cfg_we_off = 8'd7;
          cfg_ce_off = 8'd10; cfg_cap = 8'd8; cfg_bus8 = 1'b1;
        end
        if (k == 15) cfg_load = 1'b0;
      end
      drv    = wr && k >= 5 && k < m_we;
      exp_oe = drv ? (m_b8 ? 2'b01 : 2'b11) : 2'b00;
      exp_o  = drv ? (m_b8 ? {8'h00, wd[7:0]} : wd) : 16'h0000;
      chk(nand_ce_n == !(k < m_ce), "R3", "ce_n", 32'(nand_ce_n), 32'(!(k < m_ce)));
      chk(nand_oe_n == !(!wr && k >= 7 && k < m_oe), "R4", "oe_n",
          32'(nand_oe_n), 32'(!(!wr && k >= 7 && k < m_oe)));
      chk(nand_we_n == !drv, "R5", "we_n", 32'(nand_we_n), 32'(!drv));
      chk(nand_dq_oe == exp_oe, m_b8 ? "R7" : "R5", "dq_oe", 32'(nand_dq_oe), 32'(exp_oe));
      chk(nand_dq_o == exp_o, m_b8 ? "R7" : "R5", "dq_o", 32'(nand_dq_o), 32'(exp_o));
      chk(acc_done == (k == LEN - 1), "R2", "done", 32'(acc_done), 32'(k == LEN - 1));
    end
    if (!wr) m_rd = m_b8 ? {8'h00, rv[7:0]} : rv;
    chk(rd_data == m_rd, m_b8 ? "R7" : "R6", "rd_data", 32'(rd_data), 32'(m_rd));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(nand_ce_n && nand_oe_n && nand_we_n, "R1", "strobes",
        32'({nand_ce_n, nand_oe_n, nand_we_n}), 32'h7);
    chk(nand_dq_oe == 2'b00 && nand_dq_o == 16'h0, "R1", "dq", 32'(nand_dq_oe), 32'h0);
    chk(acc_done == 1'b0 && rd_data == 16'h0, "R1", "done/rd", 32'(rd_data), 32'h0);

    // R1/R8: default timing, 16-bit, read then write
    pulse_req(1'b0, 16'h0);
    run_window(1'b0, 16'h0, 16'h1234, 1'b0);
    pulse_req(1'b1, 16'hC3A5);
    run_window(1'b1, 16'hC3A5, 16'hFFFF, 1'b0);

    // Sweep of timing sets and widths
    for (int i = 0; i < 4; i++) begin
      for (int b = 0; b < 2; b++) begin
        logic [15:0] wd, rv;
        wd = 16'hA5C3 ^ 16'(i * 16'h1111) ^ 16'(b * 16'h0F0F);
        rv = 16'h3C5A + 16'(i * 257) + 16'(b * 16'h4000);
        load_cfg(8 + i * 5, 6 + i * 5, 29 - i * 2, 7 + i * 6, b[0]);
        pulse_req(1'b0, 16'h0);
        run_window(1'b0, 16'h0, rv, 1'b0);
        pulse_req(1'b1, wd);
        run_window(1'b1, wd, ~rv, 1'b0);
      end
    end

    // R10: illegal loads ignored
    load_cfg(20, 20, 28, 19, 1'b0);
    load_cfg(7, 20, 28, 19, 1'b1);
    load_cfg(20, 20, 30, 19, 1'b1);
    load_cfg(20, 25, 22, 19, 1'b1);
    load_cfg(20, 20, 28, 29, 1'b1);
    pulse_req(1'b0, 16'h0);
    run_window(1'b0, 16'h0, 16'h9876, 1'b0);   // R10 old settings still in force

    // R8: busy holds off the start
    @(negedge clk);
    nand_busy = 1'b1;
    pulse_req(1'b0, 16'h0);
    for (int w = 0; w < 10; w++) begin
      @(negedge clk);
      chk(nand_ce_n == 1'b1, "R8", "ce_n while busy", 32'(nand_ce_n), 32'h1);
      if (w == 9) nand_busy = 1'b0;
    end
    run_window(1'b0, 16'h0, 16'h5EED, 1'b0);

    // R9: queued request, ignored extra request, R10 load during window ignored
    pulse_req(1'b0, 16'h0);
    run_window(1'b0, 16'h0, 16'h4242, 1'b1);
    @(negedge clk);
    chk(nand_ce_n == 1'b1 && acc_done == 1'b0, "R2", "idle gap",
        32'({nand_ce_n, acc_done}), 32'h2);
    run_window(1'b1, 16'hBEEF, 16'h0000, 1'b0);   // R9 queued write, R10 old timing
    for (int w = 0; w < 40; w++) begin
      @(negedge clk);
      chk(nand_ce_n == 1'b1 && nand_dq_oe == 2'b00, "R9", "no third window",
          32'(nand_ce_n), 32'h1);
    end

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule